// File: doc/BRIEF.md
# Banked Global Register Selector

This block keeps several copies of the eight global integer registers and picks which copy the core sees. Each copy is a bank. Reads and writes from the core always go to the bank that is active at that moment. Register index 0 is hardwired to zero in every bank.

The block has two ways of choosing the bank, set by the `levelMode` input. In legacy mode, three bits of the processor-state word pick one of four banks: normal, alternate, MMU or interrupt. In level mode, a 3-bit global level picks one of eight banks, and the legacy selector bits in the processor-state word are cleared whenever that word is written.

The core updates the state through three paths: a processor-state write, a global-level write, and a trap return. The trap return reloads both values from fields of a saved trap-state word. Storage is indexed directly by the active bank, so changing bank needs no copying.

Top module: `gbank_top`

## Requirements
- R1: Each bank holds eight registers. A read at index 1..7 returns the value last written to that index while the same bank was active. Writes made in one bank never appear in another bank.
- R2: Index 0 reads as zero in every bank, and writes to index 0 change nothing.
- R3: In legacy mode the selector is the processor state ANDed with 0xC01. Selector 0x000 gives the normal bank (`activeBank`=0). 0x001 gives the alternate bank (1). 0x400 gives the MMU bank (2). 0x800 gives the interrupt bank (3).
- R4: In legacy mode, any selector value other than the four in R3 (for example 0xC01, 0x401, 0xC00) selects the normal bank (0).
- R5: A processor-state write stores its 12-bit data ANDed with 0xF3F, so bits 7:6 always read zero.
- R6: A processor-state write whose masked selector equals the current one keeps the same bank and its contents. The other state bits still take the new value.
- R7: In level mode the active bank equals the global level. A global-level write keeps only bits 2:0 of its data.
- R8: In level mode, a processor-state write also forces bits 0, 10 and 11 to zero, so the stored value is the data ANDed with 0x33E.
- R9: On trap return, the processor state is loaded from trap-state bits 19:8, masked as in R5 and R8. The global level is loaded from trap-state bits 42:40. A trap return takes priority over a processor-state or global-level write in the same cycle.
- R10: A register write in the same cycle as a bank-changing state write goes to the bank that was active before the change.
- R11: After reset the processor state is 0, the global level is 0, the active bank is 0, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| levelMode | input | 1 | 1: bank chosen by global level; 0: legacy processor-state selection |
| rdIdx | input | 3 | Read register index |
| rdData | output | DATA_W | Read data from the active bank (combinational) |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 3 | Write register index |
| wrData | input | DATA_W | Write data |
| psWrEn | input | 1 | Processor-state write strobe |
| psWrData | input | 12 | Processor-state write data |
| glWrEn | input | 1 | Global-level write strobe |
| glWrData | input | GLIN_W | Global-level write data (truncated to 3 bits) |
| trapRetEn | input | 1 | Trap return: reload state from `trapState` |
| trapState | input | TRAP_W | Saved trap-state word |
| psState | output | 12 | Current processor state |
| glLevel | output | 3 | Current global level |
| activeBank | output | 3 | Index of the active bank |

## Verification
The hardest case to reach from the ports is a register write that lands in the same clock edge as a bank change (R10). The bench drives both strobes together, then reads the register in the new bank (expecting its old content) and again after switching back (expecting the new data). Trap return is also exercised with competing state and level writes in the same cycle, to show that it wins (R9).

// File: rtl/gbank_pkg.sv
package gbank_pkg;
  localparam int REG_CNT  = 8;
  localparam int IDX_W    = $clog2(REG_CNT);
  localparam int BANK_CNT = 8;
  localparam int BANK_W   = $clog2(BANK_CNT);
  localparam int GL_W     = 3;
  localparam int PS_W     = 12;

  // field positions inside the saved trap-state word
  localparam int TS_PS_LSB = 8;
  localparam int TS_GL_LSB = 40;

  localparam logic [PS_W-1:0] PS_KEEP  = 12'hF3F;
  localparam logic [PS_W-1:0] SEL_MASK = 12'hC01;
  localparam logic [PS_W-1:0] SEL_ALT  = 12'h001;
  localparam logic [PS_W-1:0] SEL_MMU  = 12'h400;
  localparam logic [PS_W-1:0] SEL_INTR = 12'h800;

  typedef enum logic [BANK_W-1:0] {
    BANK_NORMAL = 3'd0,
    BANK_ALT    = 3'd1,
    BANK_MMU    = 3'd2,
    BANK_INTR   = 3'd3
  } legacyBank_e;

  typedef struct packed {
    logic              wrStb;
    logic [IDX_W-1:0]  wrIdx;
    logic [BANK_W-1:0] bank;
  } gbStrobe_t;

  function automatic logic [BANK_W-1:0] legacyDecode(input logic [PS_W-1:0] ps);
    legacyBank_e b;
    case (ps & SEL_MASK)
      SEL_ALT:  b = BANK_ALT;
      SEL_MMU:  b = BANK_MMU;
      SEL_INTR: b = BANK_INTR;
      default:  b = BANK_NORMAL;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/gbank_ctrl.sv
module gbank_ctrl
  import gbank_pkg::*;
#(
  parameter int GLIN_W = 8,
  parameter int TRAP_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 levelMode,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 psWrEn,
  input  logic [PS_W-1:0]      psWrData,
  input  logic                 glWrEn,
  input  logic [GLIN_W-1:0]    glWrData,
  input  logic                 trapRetEn,
  input  logic [TRAP_W-1:0]    trapState,
  output gbStrobe_t            stb,
  output logic [PS_W-1:0]      psState,
  output logic [GL_W-1:0]      glLevel,
  output logic [BANK_W-1:0]    activeBank
);
  logic [PS_W-1:0] psKeep;
  logic [PS_W-1:0] psSrc;
  logic [GL_W-1:0] glSrc;
  logic            psLoad;
  logic            glLoad;

  always_comb begin
    psKeep = levelMode ? (PS_KEEP & ~SEL_MASK) : PS_KEEP;
    psSrc  = trapRetEn ? trapState[TS_PS_LSB +: PS_W] : psWrData;
    glSrc  = trapRetEn ? trapState[TS_GL_LSB +: GL_W] : glWrData[GL_W-1:0];
    psLoad = trapRetEn || psWrEn;
    glLoad = trapRetEn || glWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psState <= '0;
      glLevel <= '0;
    end else begin
      if (psLoad) psState <= psSrc & psKeep;
      if (glLoad) glLevel <= glSrc;
    end
  end

  always_comb begin
    if (levelMode) activeBank = BANK_W'(glLevel);
    else           activeBank = legacyDecode(psState);
    stb.wrStb = wrEn && (wrIdx != '0);
    stb.wrIdx = wrIdx;
    stb.bank  = activeBank;
  end
endmodule

// File: rtl/gbank_dp.sv
module gbank_dp
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  gbStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankRead [BANK_CNT];

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [DATA_W-1:0] word [REG_CNT];
    assign word[0] = '0;
    for (genvar r = 1; r < REG_CNT; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)
          word[r] <= '0;
        else if (stb.wrStb && stb.bank == BANK_W'(b) && stb.wrIdx == IDX_W'(r))
          word[r] <= wrData;
      end
    end
    assign bankRead[b] = word[rdIdx];
  end

  assign rdData = bankRead[stb.bank];
endmodule

// File: rtl/gbank_top.sv
module gbank_top
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int GLIN_W = 8,
  parameter int TRAP_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              levelMode,
  input  logic [2:0]        rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [2:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              psWrEn,
  input  logic [11:0]       psWrData,
  input  logic              glWrEn,
  input  logic [GLIN_W-1:0] glWrData,
  input  logic              trapRetEn,
  input  logic [TRAP_W-1:0] trapState,
  output logic [11:0]       psState,
  output logic [2:0]        glLevel,
  output logic [2:0]        activeBank
);
  gbStrobe_t stb;

  gbank_ctrl #(.GLIN_W(GLIN_W), .TRAP_W(TRAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .levelMode(levelMode),
    .wrEn(wrEn), .wrIdx(wrIdx),
    .psWrEn(psWrEn), .psWrData(psWrData),
    .glWrEn(glWrEn), .glWrData(glWrData),
    .trapRetEn(trapRetEn), .trapState(trapState),
    .stb(stb), .psState(psState), .glLevel(glLevel), .activeBank(activeBank)
  );

  gbank_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: rtl/gbank_chk.sv
module gbank_chk
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TRAP_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              levelMode,
  input logic [2:0]        rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic              psWrEn,
  input logic              trapRetEn,
  input logic [TRAP_W-1:0] trapState,
  input logic [11:0]       psState,
  input logic [2:0]        glLevel,
  input logic [2:0]        activeBank
);
  p_idx0_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx == 3'd0 |-> rdData == '0);

  p_legacy_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    !levelMode |-> activeBank < 3'd4);

  p_ps_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (psState & ~PS_KEEP) == '0);

  p_level_bank_r7: assert property (@(posedge clk) disable iff (!rstN)
    levelMode |-> activeBank == glLevel);

  p_level_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && psWrEn && !trapRetEn) |=> (psState & SEL_MASK) == '0);

  p_trap_gl_r9: assert property (@(posedge clk) disable iff (!rstN)
    trapRetEn |=> glLevel == $past(trapState[TS_GL_LSB +: GL_W]));
endmodule

bind gbank_top gbank_chk #(.DATA_W(DATA_W), .TRAP_W(TRAP_W)) u_chk (
  .clk(clk), .rstN(rstN), .levelMode(levelMode), .rdIdx(rdIdx), .rdData(rdData),
  .psWrEn(psWrEn), .trapRetEn(trapRetEn), .trapState(trapState),
  .psState(psState), .glLevel(glLevel), .activeBank(activeBank)
);

// File: tb/gbank_top_test.sv
module gbank_top_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        levelMode = 0;
  logic [2:0]  rdIdx = 0;
  logic [63:0] rdData;
  logic        wrEn = 0;
  logic [2:0]  wrIdx = 0;
  logic [63:0] wrData = 0;
  logic        psWrEn = 0;
  logic [11:0] psWrData = 0;
  logic        glWrEn = 0;
  logic [7:0]  glWrData = 0;
  logic        trapRetEn = 0;
  logic [63:0] trapState = 0;
  logic [11:0] psState;
  logic [2:0]  glLevel;
  logic [2:0]  activeBank;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gbank_top uut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] i, logic [63:0] d);
    @(negedge clk); wrEn = 1; wrIdx = i; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic setPs(logic [11:0] v);
    @(negedge clk); psWrEn = 1; psWrData = v;
    @(negedge clk); psWrEn = 0;
  endtask

  task automatic setGl(logic [7:0] v);
    @(negedge clk); glWrEn = 1; glWrData = v;
    @(negedge clk); glWrEn = 0;
  endtask

  task automatic rdChk(string tag, logic [2:0] i, logic [63:0] exp);
    rdIdx = i; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic t_reset();
    chk("R11 psState", 64'(psState), 0);
    chk("R11 glLevel", 64'(glLevel), 0);
    chk("R11 activeBank", 64'(activeBank), 0);
    rdChk("R11 reg3", 3'd3, 0);
  endtask

  task automatic t_banks();
    levelMode = 0;
    setPs(12'h000); wrReg(3, 64'hA);
    setPs(12'h001); chk("R3 alt bank", 64'(activeBank), 1); wrReg(3, 64'hB);
    rdChk("R1 alt r3", 3, 64'hB);
    setPs(12'h400); chk("R3 mmu bank", 64'(activeBank), 2);
    rdChk("R1 mmu r3 untouched", 3, 0); wrReg(3, 64'hC);
    setPs(12'h800); chk("R3 intr bank", 64'(activeBank), 3); wrReg(3, 64'hD);
    setPs(12'h000); chk("R3 normal bank", 64'(activeBank), 0);
    rdChk("R1 normal r3", 3, 64'hA);
    setPs(12'h001); rdChk("R1 alt r3 again", 3, 64'hB);
    setPs(12'h400); rdChk("R1 mmu r3", 3, 64'hC);
  endtask

  task automatic t_zero();
    setPs(12'h800); wrReg(0, 64'hFFFF);
    rdChk("R2 idx0 intr", 0, 0);
    setPs(12'h000); wrReg(0, 64'h1234);
    rdChk("R2 idx0 normal", 0, 0);
    rdChk("R2 r3 intact", 3, 64'hA);
  endtask

  task automatic t_fallback();
    setPs(12'hC01); chk("R4 0xC01", 64'(activeBank), 0); rdChk("R4 read normal", 3, 64'hA);
    setPs(12'h401); chk("R4 0x401", 64'(activeBank), 0);
    setPs(12'hC00); chk("R4 0xC00", 64'(activeBank), 0);
  endtask

  task automatic t_mask();
    setPs(12'hFFF);
    chk("R5 masked", 64'(psState), 64'hF3F);
    setPs(12'h0C0);
    chk("R5 bits 7:6", 64'(psState), 0);
  endtask

  task automatic t_unchanged();
    setPs(12'h001); wrReg(5, 64'hE);
    setPs(12'h03F);
    chk("R6 psState", 64'(psState), 64'h03F);
    chk("R6 bank kept", 64'(activeBank), 1);
    rdChk("R6 r5 kept", 5, 64'hE);
  endtask

  task automatic t_level();
    levelMode = 1;
    setGl(8'hFD);
    chk("R7 gl trunc", 64'(glLevel), 5);
    chk("R7 bank=gl", 64'(activeBank), 5);
    wrReg(2, 64'hF);
    setGl(8'h0A); chk("R7 gl 2", 64'(activeBank), 2);
    rdChk("R7 bank2 r2", 2, 0);
    setGl(8'h05); rdChk("R7 bank5 r2", 2, 64'hF);
    setPs(12'hFFF);
    chk("R8 legacy bits cleared", 64'(psState), 64'h33E);
  endtask

  task automatic t_trap();
    levelMode = 1;
    @(negedge clk);
    trapRetEn = 1; trapState = (64'd6 << 40) | (64'hC05 << 8);
    psWrEn = 1; psWrData = 12'h100; glWrEn = 1; glWrData = 8'd1;
    @(negedge clk);
    trapRetEn = 0; psWrEn = 0; glWrEn = 0;
    chk("R9 level ps", 64'(psState), 64'h004);
    chk("R9 level gl", 64'(glLevel), 6);
    levelMode = 0;
    @(negedge clk);
    trapRetEn = 1; trapState = (64'd3 << 40) | (64'h800 << 8);
    @(negedge clk); trapRetEn = 0;
    chk("R9 legacy ps", 64'(psState), 64'h800);
    chk("R9 legacy gl", 64'(glLevel), 3);
    chk("R9 legacy bank", 64'(activeBank), 3);
  endtask

  task automatic t_sameCycle();
    levelMode = 0;
    setPs(12'h000);
    @(negedge clk);
    wrEn = 1; wrIdx = 6; wrData = 64'h6A6A;
    psWrEn = 1; psWrData = 12'h001;
    @(negedge clk); wrEn = 0; psWrEn = 0;
    chk("R10 bank moved", 64'(activeBank), 1);
    rdChk("R10 new bank r6", 6, 0);
    setPs(12'h000);
    rdChk("R10 old bank r6", 6, 64'h6A6A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_zero();
    t_fallback();
    t_mask();
    t_unchanged();
    t_level();
    t_trap();
    t_sameCycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule